// File: doc/BRIEF.md
# Multicycle Processor Datapath with Buffer Registers

This block is the datapath of a 32-bit processor that runs each instruction over several clock cycles. One ALU does all the arithmetic. It computes the incremented program counter, the branch target and the execute-stage result, each in a different cycle. Memory sits behind a single port that serves both instruction fetch and data access. Values that must outlive a cycle are kept in buffer registers: the instruction register, the memory data register, the two operand registers and the ALU result register.

An external sequencer drives every select and write-enable, one cycle at a time. The datapath returns the current opcode and the ALU zero flag so that the sequencer can choose its next step. Memory read data for the address presented in a cycle must be valid before the end of that cycle, because the instruction register and the memory data register capture it at the closing edge. The store data output always carries the operand register that was read through the rt field.

Instruction fields:

| Field | Bits |
|---|---|
| opcode | 31..26 |
| rs | 25..21 |
| rt | 20..16 |
| rd | 15..11 |
| offset | 15..0 |
| jump field | 25..0 |

Top module: `mcdp_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC, the instruction register and all buffer registers clear to zero, so after reset `mem_addr` and `opcode` read 0.
- R2: The instruction register loads `mem_rdata` at a clock edge only when `ir_we` is high, and it otherwise holds its value. `opcode` always shows bits 31..26 of the instruction register.
- R3: `mem_addr` is the PC when `iord` is 0 and the ALU result register when `iord` is 1.
- R4: `alu_op` selects the ALU function: 0 add, 1 subtract, 2 AND, 3 OR, 4 signed set-less-than (result 1 or 0). `zero` is high exactly when the current ALU result is all zeros.
- R5: `src_a` selects the first ALU operand: 0 gives the PC and 1 gives operand register A. `src_b` selects the second: 0 gives operand register B, 1 gives the constant 4, 2 gives the sign-extended offset, and 3 gives the sign-extended offset shifted left by 2.
- R6: The memory data register, the operand registers A and B (read from the register file through rs and rt), and the ALU result register load at every clock edge. `mem_wdata` shows B.
- R7: The PC loads only when `pc_we` is high. `pc_sel` picks its next value: 0 gives the current ALU result, 1 gives the ALU result register, and 2 gives the jump target, which is PC bits 31..28 joined with the 26-bit jump field and two zero bits.
- R8: When `reg_we` is high, the register file writes at the clock edge. The destination is rd when `reg_dst` is 1 and rt when it is 0. The data comes from the memory data register when `mem_to_reg` is 1 and from the ALU result register when it is 0.
- R9: Register 0 always reads as zero, and writes that target it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_we | input | 1 | PC write enable |
| iord | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| ir_we | input | 1 | Instruction register write enable |
| reg_we | input | 1 | Register file write enable |
| reg_dst | input | 1 | Destination select: 0 rt, 1 rd |
| mem_to_reg | input | 1 | Write data select: 0 ALU result register, 1 memory data register |
| src_a | input | 1 | First ALU operand select |
| src_b | input | 2 | Second ALU operand select |
| alu_op | input | 3 | ALU function |
| pc_sel | input | 2 | PC source select |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (operand register B) |
| opcode | output | 6 | Instruction register bits 31..26 |
| zero | output | 1 | ALU result is zero |

## Verification
A wrong buffer register does not hide for long. A bad ALU result register shows on `mem_addr` in the very next cycle that has `iord` set, and it shows in the address of the next fetch after a branch. A corrupted instruction register shows on `opcode` at once. A wrong register-file entry first appears on `mem_wdata`, one cycle after a decode that names it as rt. Through A it reaches `mem_addr` two cycles after that decode. A PC that advanced when it should have held shows as a wrong fetch address on the next instruction.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int RIDX    = $clog2(NREGS);
    localparam int OPW     = 6;
    localparam int OFFW    = 16;
    localparam int JFW     = 26;
    localparam int PCHI    = XLEN - JFW - 2;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        OPB_REG   = 2'd0,
        OPB_FOUR  = 2'd1,
        OPB_OFF   = 2'd2,
        OPB_OFFSH = 2'd3
    } opb_sel_e;

    typedef enum logic [1:0] {
        PCN_ALU    = 2'd0,
        PCN_ALUREG = 2'd1,
        PCN_JUMP   = 2'd2
    } pc_next_e;

    typedef struct packed {
        logic [OPW-1:0]  op;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
        logic [OFFW-1:0] off;
        logic [JFW-1:0]  jfield;
    } ifields_t;

    function automatic ifields_t split_instr(input logic [XLEN-1:0] w);
        ifields_t f;
        f.op     = w[31:26];
        f.rs     = w[25:21];
        f.rt     = w[20:16];
        f.rd     = w[15:11];
        f.off    = w[15:0];
        f.jfield = w[25:0];
        return f;
    endfunction

    function automatic logic [XLEN-1:0] sext_off(input logic [OFFW-1:0] v);
        return {{(XLEN-OFFW){v[OFFW-1]}}, v};
    endfunction

endpackage

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    ra1,
    input  logic [AW-1:0]    ra2,
    output logic [WIDTH-1:0] rd1,
    output logic [WIDTH-1:0] rd2,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);

    logic [WIDTH-1:0] regs [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        if (g == 0) begin : g_hard_zero
            assign regs[g] = '0;
        end else begin : g_flop
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= '0;
                else if (we && wa == AW'(g))
                    regs[g] <= wd;
            end
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
    import mcdp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = WIDTH'($signed(a) < $signed(b));
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mcdp_pc_unit.sv
module mcdp_pc_unit
    import mcdp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            pc_we,
    input  pc_next_e        sel,
    input  logic [XLEN-1:0] alu_y,
    input  logic [XLEN-1:0] alu_reg,
    input  logic [JFW-1:0]  jfield,
    output logic [XLEN-1:0] pc
);

    logic [XLEN-1:0] jtarget;
    logic [XLEN-1:0] pc_next;

    assign jtarget = {pc[XLEN-1 -: PCHI], jfield, 2'b00};

    always_comb begin
        unique case (sel)
            PCN_ALUREG: pc_next = alu_reg;
            PCN_JUMP:   pc_next = jtarget;
            default:    pc_next = alu_y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else if (pc_we)
            pc <= pc_next;
    end

endmodule

// File: rtl/mcdp_core.sv
module mcdp_core
    import mcdp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pc_we,
    input  logic        iord,
    input  logic        ir_we,
    input  logic        reg_we,
    input  logic        reg_dst,
    input  logic        mem_to_reg,
    input  logic        src_a,
    input  logic [1:0]  src_b,
    input  logic [2:0]  alu_op,
    input  logic [1:0]  pc_sel,
    input  logic [31:0] mem_rdata,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [5:0]  opcode,
    output logic        zero
);

    logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
    logic [XLEN-1:0] rf_rd1, rf_rd2, opa, opb, alu_y, wb_data;
    logic [RIDX-1:0] wb_idx;
    ifields_t        fld;

    assign fld = split_instr(ir_q);

    mcdp_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) i_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (fld.rs),
        .ra2 (fld.rt),
        .rd1 (rf_rd1),
        .rd2 (rf_rd2),
        .we  (reg_we),
        .wa  (wb_idx),
        .wd  (wb_data)
    );

    assign opa = src_a ? a_q : pc_q;

    always_comb begin
        unique case (opb_sel_e'(src_b))
            OPB_REG:   opb = b_q;
            OPB_FOUR:  opb = XLEN'(4);
            OPB_OFF:   opb = sext_off(fld.off);
            default:   opb = sext_off(fld.off) << 2;
        endcase
    end

    mcdp_alu #(.WIDTH(XLEN)) i_alu (
        .op   (alu_op_e'(alu_op)),
        .a    (opa),
        .b    (opb),
        .y    (alu_y),
        .zero (zero)
    );

    mcdp_pc_unit i_pcu (
        .clk     (clk),
        .rst     (rst),
        .pc_we   (pc_we),
        .sel     (pc_next_e'(pc_sel)),
        .alu_y   (alu_y),
        .alu_reg (aluout_q),
        .jfield  (fld.jfield),
        .pc      (pc_q)
    );

    assign wb_idx  = reg_dst ? fld.rd : fld.rt;
    assign wb_data = mem_to_reg ? mdr_q : aluout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q     <= '0;
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            if (ir_we)
                ir_q <= mem_rdata;
            mdr_q    <= mem_rdata;
            a_q      <= rf_rd1;
            b_q      <= rf_rd2;
            aluout_q <= alu_y;
        end
    end

    assign mem_addr  = iord ? aluout_q : pc_q;
    assign mem_wdata = b_q;
    assign opcode    = fld.op;

endmodule

// File: rtl/mcdp_core_chk.sv
module mcdp_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        ir_we,
    input logic        pc_we,
    input logic [1:0]  pc_sel,
    input logic [31:0] pc_q,
    input logic [31:0] ir_q,
    input logic [31:0] a_q,
    input logic [31:0] aluout_q
);

    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: one edge with reset high leaves PC and IR cleared
    always @(negedge clk) begin
        if (rst_seen) begin
            a_r1_reset_clears: assert (pc_q == 32'd0 && ir_q == 32'd0)
                else $error("R1 state not cleared by reset");
        end
    end

    a_r2_ir_hold: assert property (@(posedge clk) disable iff (rst)
        !ir_we |=> $stable(ir_q));

    a_r7_pc_hold: assert property (@(posedge clk) disable iff (rst)
        !pc_we |=> $stable(pc_q));

    a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pc_sel == 2'd2) |=>
        pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00});

    a_r7_branch_from_reg: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pc_sel == 2'd1) |=> pc_q == $past(aluout_q));

    a_r9_rs_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (ir_q[25:21] == 5'd0) |=> a_q == 32'd0);

endmodule

bind mcdp_core mcdp_core_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .ir_we    (ir_we),
    .pc_we    (pc_we),
    .pc_sel   (pc_sel),
    .pc_q     (pc_q),
    .ir_q     (ir_q),
    .a_q      (a_q),
    .aluout_q (aluout_q)
);

// File: tb/test_mcdp_core.sv
module test_mcdp_core;

    logic        clk = 1'b0;
    logic        rst;
    logic        pc_we, iord, ir_we, reg_we, reg_dst, mem_to_reg, src_a;
    logic [1:0]  src_b, pc_sel;
    logic [2:0]  alu_op;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic [5:0]  opcode;
    logic        zero;

    always #4 clk = ~clk;

    mcdp_core i_mcdp_core (
        .clk(clk), .rst(rst), .pc_we(pc_we), .iord(iord), .ir_we(ir_we),
        .reg_we(reg_we), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
        .src_a(src_a), .src_b(src_b), .alu_op(alu_op), .pc_sel(pc_sel),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .opcode(opcode), .zero(zero)
    );

    logic [31:0] mem [0:63];
    always_comb mem_rdata = mem[mem_addr[7:2]];

    logic [31:0] rmodel [0:31];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    task automatic expect_out(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    // monitor: compares every queued expectation mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    0: act = mem_addr;
                    1: act = mem_wdata;
                    2: act = {26'd0, opcode};
                    default: act = {31'd0, zero};
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic drive(input logic pw, input logic io, input logic irw, input logic rw,
                         input logic rdst, input logic m2r, input logic sa,
                         input logic [1:0] sb, input logic [2:0] op, input logic [1:0] ps);
        @(posedge clk);
        #1;
        pc_we = pw; iord = io; ir_we = irw; reg_we = rw; reg_dst = rdst;
        mem_to_reg = m2r; src_a = sa; src_b = sb; alu_op = op; pc_sel = ps;
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] alu_ref(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd);
        return {6'd0, rs, rt, rd, 11'd0};
    endfunction

    logic [31:0] pc;

    task automatic fetch_decode(input logic [31:0] instr);
        drive(1, 0, 1, 0, 0, 0, 0, 2'd1, 3'd0, 2'd0);
        expect_out(0, pc, "R3 fetch address is PC");
        drive(0, 0, 0, 0, 0, 0, 0, 2'd3, 3'd0, 2'd0);
        expect_out(2, {26'd0, instr[31:26]}, "R2 opcode after IR load");
        expect_out(0, pc + 32'd4, "R7 PC advanced by ALU result");
    endtask

    task automatic do_load(input logic [31:0] instr);
        logic [31:0] addr;
        addr = rmodel[instr[25:21]] + sx(instr[15:0]);
        fetch_decode(instr);
        drive(0, 1, 0, 0, 0, 0, 1, 2'd2, 3'd0, 2'd0);
        expect_out(0, pc + 32'd4 + (sx(instr[15:0]) << 2), "R5 PC plus shifted offset");
        drive(0, 1, 0, 0, 0, 0, 1, 2'd2, 3'd0, 2'd0);
        expect_out(0, addr, "R3 data address from ALU register");
        drive(0, 0, 0, 1, 0, 1, 1, 2'd2, 3'd0, 2'd0);
        expect_out(0, pc + 32'd4, "R7 PC held while pc_we low");
        expect_out(2, {26'd0, instr[31:26]}, "R2 IR held while ir_we low");
        if (instr[20:16] != 5'd0) rmodel[instr[20:16]] = mem[addr[7:2]];
        pc = pc + 32'd4;
    endtask

    task automatic do_rtype(input logic [31:0] instr, input logic [2:0] op);
        logic [31:0] res;
        res = alu_ref(op, rmodel[instr[25:21]], rmodel[instr[20:16]]);
        fetch_decode(instr);
        drive(0, 1, 0, 0, 0, 0, 1, 2'd0, op, 2'd0);
        expect_out(0, pc + 32'd4 + (sx(instr[15:0]) << 2), "R6 ALU register holds decode result");
        expect_out(1, rmodel[instr[20:16]], "R6 B shows rt value R8 R9");
        expect_out(3, {31'd0, res == 32'd0}, "R4 zero flag");
        drive(0, 1, 0, 1, 1, 0, 1, 2'd0, op, 2'd0);
        expect_out(0, res, "R4 ALU function result R5 operand A");
        if (instr[15:11] != 5'd0) rmodel[instr[15:11]] = res;
        pc = pc + 32'd4;
    endtask

    task automatic do_branch(input logic [31:0] instr);
        logic taken;
        logic [31:0] tgt;
        taken = (rmodel[instr[25:21]] == rmodel[instr[20:16]]);
        tgt = pc + 32'd4 + (sx(instr[15:0]) << 2);
        fetch_decode(instr);
        drive(taken, 0, 0, 0, 0, 0, 1, 2'd0, 3'd1, 2'd1);
        expect_out(3, {31'd0, taken}, "R4 compare zero flag");
        pc = taken ? tgt : pc + 32'd4;
    endtask

    task automatic do_jump(input logic [31:0] instr);
        logic [31:0] pc4;
        pc4 = pc + 32'd4;
        fetch_decode(instr);
        drive(1, 0, 0, 0, 0, 0, 0, 2'd0, 3'd0, 2'd2);
        pc = {pc4[31:28], instr[25:0], 2'b00};
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        for (int i = 0; i < 32; i++) rmodel[i] = 32'd0;
        mem[40] = 32'h0000_0015;
        mem[41] = 32'hFFFF_FFF8;
        mem[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h00A0);
        mem[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'h00A4);
        mem[2]  = enc_r(5'd1, 5'd2, 5'd3);
        mem[3]  = enc_r(5'd1, 5'd1, 5'd4);
        mem[4]  = enc_r(5'd1, 5'd2, 5'd5);
        mem[5]  = enc_r(5'd1, 5'd2, 5'd6);
        mem[6]  = enc_r(5'd2, 5'd1, 5'd7);
        mem[7]  = enc_r(5'd1, 5'd2, 5'd8);
        mem[8]  = enc_r(5'd1, 5'd1, 5'd0);
        mem[9]  = enc_r(5'd0, 5'd0, 5'd9);
        mem[10] = enc_r(5'd3, 5'd0, 5'd10);
        mem[11] = enc_i(6'h04, 5'd1, 5'd1, 16'h0003);
        mem[15] = enc_i(6'h04, 5'd1, 5'd2, 16'h0005);
        mem[16] = {6'h02, 26'h000_0020};
        mem[32] = enc_i(6'h04, 5'd1, 5'd1, 16'hFFFF);

        rst = 1'b1;
        pc_we = 0; iord = 0; ir_we = 0; reg_we = 0; reg_dst = 0;
        mem_to_reg = 0; src_a = 0; src_b = 2'd0; alu_op = 3'd0; pc_sel = 2'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        expect_out(0, 32'd0, "R1 address after reset");
        expect_out(2, 32'd0, "R1 opcode after reset");
        expect_out(1, 32'd0, "R1 store data after reset");
        pc = 32'd0;

        do_load(mem[0]);
        do_load(mem[1]);
        do_rtype(mem[2], 3'd0);
        do_rtype(mem[3], 3'd1);
        do_rtype(mem[4], 3'd2);
        do_rtype(mem[5], 3'd3);
        do_rtype(mem[6], 3'd4);
        do_rtype(mem[7], 3'd4);
        do_rtype(mem[8], 3'd0);
        do_rtype(mem[9], 3'd3);
        do_rtype(mem[10], 3'd0);
        do_branch(mem[11]);
        drive(0, 0, 0, 0, 0, 0, 0, 2'd0, 3'd0, 2'd0);
        expect_out(0, pc, "R7 taken branch loads ALU register");
        do_branch(mem[15]);
        drive(0, 0, 0, 0, 0, 0, 0, 2'd0, 3'd0, 2'd0);
        expect_out(0, pc, "R7 untaken branch keeps PC plus 4");
        do_jump(mem[16]);
        drive(0, 0, 0, 0, 0, 0, 0, 2'd0, 3'd0, 2'd0);
        expect_out(0, pc, "R7 jump target");
        do_branch(mem[32]);
        drive(0, 0, 0, 0, 0, 0, 0, 2'd0, 3'd0, 2'd0);
        expect_out(0, pc, "R5 negative offset sign extension");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule